// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit datapath. It holds an accumulator and a five-bit status register. Each operation takes the accumulator and one external operand. The block computes one of ten functions: add, add with carry, subtract, subtract with borrow, AND, OR, XOR, compare, increment and decrement. It writes the result back into the accumulator and updates the sign, zero, auxiliary-carry, parity and carry flags. Instruction decode and register-file access happen elsewhere. A surrounding controller supplies a 4-bit operation code and the operand, and can also load the accumulator directly.

The flag register is always presented as a full byte with fixed filler bits. That byte sits next to the accumulator in a 16-bit status word, which can be saved and restored as a unit. Every update lands on a rising clock edge and can be seen on the outputs for the whole following cycle.

Top module: `alu8_status`

## Requirements
- R1: While reset is held, and until the first operation after it, `acc_q` is 0x00, `flags_q` is 0x02 and `psw_q` is 0x0002.
- R2: When `acc_load` is high at a clock edge, the accumulator takes `load_data` and the flags keep their value. This holds even if `op_valid` is high in the same cycle.
- R3: Op code 0 (add) writes A+B and op code 1 (add with carry) writes A+B+CY. In both cases CY becomes the carry out of bit 7.
- R4: Op code 2 (subtract) writes A-B and op code 3 (subtract with borrow) writes A-B-CY. In both cases CY becomes 1 when a borrow out of bit 7 occurs (A < B, or A < B+CY).
- R5: Op code 7 (compare) sets every flag exactly as subtract would, and leaves the accumulator unchanged.
- R6: Op codes 4, 5 and 6 (AND, OR, XOR) write the bitwise result and clear CY. AC becomes 1 for AND and 0 for OR and XOR.
- R7: Op code 8 (increment) writes A+1 and op code 9 (decrement) writes A-1. Both leave CY unchanged. AC is set on increment when the low nibble of A is 0xF, and on decrement when the low nibble of A is 0x0.
- R8: After every flag-writing operation, S equals bit 7 of the result, Z is 1 exactly when the 8-bit result is zero, and P is 1 exactly when the result holds an even number of one bits.
- R9: For add-type operations, AC is the carry out of bit 3. For subtract-type operations, AC is the borrow out of bit 3.
- R10: The flag byte is laid out as bit7 S, bit6 Z, bit5 0, bit4 AC, bit3 0, bit2 P, bit1 1, bit0 CY. `psw_q` is {accumulator, flag byte}.
- R11: Op codes 10 to 15, and any cycle with `op_valid` low, leave both the accumulator and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_load | input | 1 | Load the accumulator from `load_data` |
| load_data | input | 8 | Value to load into the accumulator |
| op_valid | input | 1 | Execute the operation named by `op_sel` |
| op_sel | input | 4 | Operation code (0 to 9 defined) |
| operand | input | 8 | Second operand B |
| acc_q | output | 8 | Accumulator |
| flags_q | output | 8 | Flag byte |
| psw_q | output | 16 | Accumulator and flag byte side by side |

## Verification
Each operation or load presented before a rising edge changes `acc_q`, `flags_q` and `psw_q` at that edge and at no later one, so every result is due exactly one cycle after its stimulus. The bench changes inputs on falling edges, holds them for one cycle, and compares the outputs at the next falling edge, which is half a cycle after the edge that updated them. Carry-dependent cases are first brought to a known CY value through ordinary add operations. The flag byte is then recorded from the ports just before the operation under test, so that the expected values for increment, decrement and ignored codes use that observed byte. After reset, the bench waits for the internal two-stage reset release before it drives anything.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

  // Stored status bits; filler bits of the byte are generated at the output.
  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flag_set_t;

  localparam int FLAG_W  = 8;
  localparam int POS_S   = 7;
  localparam int POS_Z   = 6;
  localparam int POS_AC  = 4;
  localparam int POS_P   = 2;
  localparam int POS_ONE = 1;
  localparam int POS_CY  = 0;

  localparam flag_set_t FLAGS_RESET = '{s: 1'b0, z: 1'b0, ac: 1'b0, p: 1'b0, cy: 1'b0};

endpackage

// File: rtl/alu8_rst_sync.sv
module alu8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/alu8_addsub.sv
// Split adder/subtractor: low nibble and high part computed separately so the
// nibble carry (or borrow) is a real internal signal rather than a derived one.
module alu8_addsub #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              aux
);

  localparam int HI_W = DATA_W - NIB_W;

  logic [NIB_W:0] lo_sum;
  logic [HI_W:0]  hi_sum;
  logic [NIB_W:0] lo_a, lo_b, lo_c;
  logic [HI_W:0]  hi_a, hi_b, hi_c;

  always_comb begin
    lo_a = {1'b0, a[NIB_W-1:0]};
    lo_b = {1'b0, b[NIB_W-1:0]};
    lo_c = {{NIB_W{1'b0}}, cin};
    if (sub) begin
      lo_sum = lo_a - lo_b - lo_c;
    end else begin
      lo_sum = lo_a + lo_b + lo_c;
    end

    hi_a = {1'b0, a[DATA_W-1:NIB_W]};
    hi_b = {1'b0, b[DATA_W-1:NIB_W]};
    hi_c = {{HI_W{1'b0}}, lo_sum[NIB_W]};
    if (sub) begin
      hi_sum = hi_a - hi_b - hi_c;
    end else begin
      hi_sum = hi_a + hi_b + hi_c;
    end

    res   = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
    aux   = lo_sum[NIB_W];
    carry = hi_sum[HI_W];
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic_sel_e        sel,
  output logic [DATA_W-1:0] res
);

  always_comb begin
    case (sel)
      LG_AND:  res = a & b;
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      default: res = a & b;
    endcase
  end

endmodule

// File: rtl/alu8_flag_eval.sv
module alu8_flag_eval
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] res,
  input  logic              ac_in,
  input  logic              cy_in,
  output flag_set_t         flags
);

  always_comb begin
    flags.s  = res[DATA_W-1];
    flags.z  = (res == '0);
    flags.ac = ac_in;
    flags.p  = ~(^res);
    flags.cy = cy_in;
  end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_load,
  input  logic [DATA_W-1:0]        load_data,
  input  logic                     op_valid,
  input  logic [3:0]               op_sel,
  input  logic [DATA_W-1:0]        operand,
  output logic [DATA_W-1:0]        acc_q,
  output logic [FLAG_W-1:0]        flags_q,
  output logic [DATA_W+FLAG_W-1:0] psw_q
);

  logic rst_int_n;

  alu8_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_int_n)
  );

  // ---------------- state ----------------
  logic [DATA_W-1:0] acc_r, acc_d;
  flag_set_t         flg_r, flg_d;
  logic              acc_en, flg_en;

  // ---------------- decode ----------------
  alu_op_e           op;
  logic [DATA_W-1:0] b_sel;
  logic              do_sub, do_cin, use_arith, wr_acc, wr_flg, keep_cy, lg_ac;
  logic_sel_e        lg_sel;

  assign op = alu_op_e'(op_sel);

  always_comb begin
    b_sel     = operand;
    do_sub    = 1'b0;
    do_cin    = 1'b0;
    use_arith = 1'b1;
    wr_acc    = 1'b0;
    wr_flg    = 1'b0;
    keep_cy   = 1'b0;
    lg_ac     = 1'b0;
    lg_sel    = LG_AND;
    case (op)
      OP_ADD: begin wr_acc = 1'b1; wr_flg = 1'b1; end
      OP_ADC: begin wr_acc = 1'b1; wr_flg = 1'b1; do_cin = flg_r.cy; end
      OP_SUB: begin wr_acc = 1'b1; wr_flg = 1'b1; do_sub = 1'b1; end
      OP_SBB: begin wr_acc = 1'b1; wr_flg = 1'b1; do_sub = 1'b1; do_cin = flg_r.cy; end
      OP_AND: begin wr_acc = 1'b1; wr_flg = 1'b1; use_arith = 1'b0; lg_sel = LG_AND; lg_ac = 1'b1; end
      OP_OR:  begin wr_acc = 1'b1; wr_flg = 1'b1; use_arith = 1'b0; lg_sel = LG_OR; end
      OP_XOR: begin wr_acc = 1'b1; wr_flg = 1'b1; use_arith = 1'b0; lg_sel = LG_XOR; end
      OP_CMP: begin wr_flg = 1'b1; do_sub = 1'b1; end
      OP_INC: begin wr_acc = 1'b1; wr_flg = 1'b1; keep_cy = 1'b1; b_sel = DATA_W'(1); end
      OP_DEC: begin wr_acc = 1'b1; wr_flg = 1'b1; keep_cy = 1'b1; do_sub = 1'b1; b_sel = DATA_W'(1); end
      default: begin wr_acc = 1'b0; wr_flg = 1'b0; end
    endcase
  end

  // ---------------- datapath ----------------
  logic [DATA_W-1:0] arith_res, logic_res, alu_res;
  logic              arith_cy, arith_ac, res_ac, res_cy;
  flag_set_t         flg_new;

  alu8_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) i_addsub (
    .a    (acc_r),
    .b    (b_sel),
    .sub  (do_sub),
    .cin  (do_cin),
    .res  (arith_res),
    .carry(arith_cy),
    .aux  (arith_ac)
  );

  alu8_logic #(.DATA_W(DATA_W)) i_logic (
    .a  (acc_r),
    .b  (operand),
    .sel(lg_sel),
    .res(logic_res)
  );

  always_comb begin
    if (use_arith) begin
      alu_res = arith_res;
      res_ac  = arith_ac;
      res_cy  = keep_cy ? flg_r.cy : arith_cy;
    end else begin
      alu_res = logic_res;
      res_ac  = lg_ac;
      res_cy  = 1'b0;
    end
  end

  alu8_flag_eval #(.DATA_W(DATA_W)) i_flag_eval (
    .res  (alu_res),
    .ac_in(res_ac),
    .cy_in(res_cy),
    .flags(flg_new)
  );

  // ---------------- next state ----------------
  always_comb begin
    acc_d  = acc_r;
    flg_d  = flg_r;
    acc_en = 1'b0;
    flg_en = 1'b0;
    if (acc_load) begin
      acc_d  = load_data;
      acc_en = 1'b1;
    end else if (op_valid) begin
      acc_d  = alu_res;
      flg_d  = flg_new;
      acc_en = wr_acc;
      flg_en = wr_flg;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc_r <= '0;
    end else if (acc_en) begin
      acc_r <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      flg_r <= FLAGS_RESET;
    end else if (flg_en) begin
      flg_r <= flg_d;
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    flags_q          = '0;
    flags_q[POS_S]   = flg_r.s;
    flags_q[POS_Z]   = flg_r.z;
    flags_q[POS_AC]  = flg_r.ac;
    flags_q[POS_P]   = flg_r.p;
    flags_q[POS_ONE] = 1'b1;
    flags_q[POS_CY]  = flg_r.cy;
  end

  assign acc_q = acc_r;
  assign psw_q = {acc_r, flags_q};

  // ---------------- assertions ----------------
  logic cmd_op;
  assign cmd_op = op_valid && !acc_load;

  assert_load_keeps_flags_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_load |=> ($stable(flags_q) && acc_q == $past(load_data)));

  assert_cmp_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_op && op_sel == 4'd7) |=> $stable(acc_q));

  assert_logic_clears_cy_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_op && (op_sel == 4'd4 || op_sel == 4'd5 || op_sel == 4'd6)) |=> (flags_q[POS_CY] == 1'b0));

  assert_incdec_keeps_cy_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_op && (op_sel == 4'd8 || op_sel == 4'd9)) |=> $stable(flags_q[POS_CY]));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_op && op_sel <= 4'd9 && op_sel != 4'd7) |=> (flags_q[POS_Z] == (acc_q == '0)));

  assert_parity_sign_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_op && op_sel <= 4'd9 && op_sel != 4'd7) |=>
      (flags_q[POS_P] == ~(^acc_q) && flags_q[POS_S] == acc_q[DATA_W-1]));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!acc_load && (!op_valid || op_sel > 4'd9)) |=> ($stable(acc_q) && $stable(flags_q)));

endmodule

// File: tb/test_alu8_status.sv
module test_alu8_status;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_load;
  logic [7:0]  load_data;
  logic        op_valid;
  logic [3:0]  op_sel;
  logic [7:0]  operand;
  logic [7:0]  acc_q;
  logic [7:0]  flags_q;
  logic [15:0] psw_q;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu8_status i_alu8_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_load (acc_load),
    .load_data(load_data),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .operand  (operand),
    .acc_q    (acc_q),
    .flags_q  (flags_q),
    .psw_q    (psw_q)
  );

  // {op[3:0], a[7:0], b[7:0], cy_in}
  localparam int NVEC = 28;
  localparam logic [20:0] VEC [NVEC] = '{
    {4'd0, 8'h3A, 8'h26, 1'b0},  // R3 R9 add, nibble carry
    {4'd0, 8'hFF, 8'h01, 1'b0},  // R3 R8 carry out, zero
    {4'd0, 8'h70, 8'h10, 1'b1},  // R3 R8 sign
    {4'd1, 8'h0F, 8'h00, 1'b1},  // R3 R9 adc, carry into nibble
    {4'd1, 8'hFE, 8'h01, 1'b1},  // R3 adc wraps
    {4'd1, 8'h12, 8'h34, 1'b0},  // R3 adc cy clear
    {4'd2, 8'h50, 8'h20, 1'b0},  // R4 sub no borrow
    {4'd2, 8'h20, 8'h21, 1'b1},  // R4 R9 borrow
    {4'd2, 8'h44, 8'h44, 1'b0},  // R4 R8 zero
    {4'd3, 8'h10, 8'h0F, 1'b1},  // R4 R9 sbb nibble borrow
    {4'd3, 8'h00, 8'h00, 1'b1},  // R4 sbb borrow from cy only
    {4'd3, 8'h80, 8'h01, 1'b0},  // R4 sbb cy clear
    {4'd4, 8'hF0, 8'h3C, 1'b1},  // R6 and
    {4'd4, 8'h0F, 8'hF0, 1'b1},  // R6 R8 and zero
    {4'd5, 8'h81, 8'h02, 1'b1},  // R6 or
    {4'd6, 8'hAA, 8'hFF, 1'b1},  // R6 xor
    {4'd6, 8'h5A, 8'h5A, 1'b0},  // R6 xor zero
    {4'd7, 8'h30, 8'h40, 1'b0},  // R5 compare less
    {4'd7, 8'h40, 8'h40, 1'b1},  // R5 compare equal
    {4'd7, 8'h41, 8'h32, 1'b0},  // R5 compare greater
    {4'd8, 8'h0F, 8'h00, 1'b1},  // R7 inc low nibble F
    {4'd8, 8'hFF, 8'h00, 1'b0},  // R7 inc wraps, cy kept 0
    {4'd8, 8'h7E, 8'h00, 1'b1},  // R7 inc plain
    {4'd9, 8'h10, 8'h00, 1'b0},  // R7 dec low nibble 0
    {4'd9, 8'h01, 8'h00, 1'b1},  // R7 dec to zero, cy kept 1
    {4'd9, 8'h00, 8'h00, 1'b0},  // R7 dec wraps
    {4'd10, 8'h55, 8'h11, 1'b1}, // R11 undefined code
    {4'd15, 8'hA3, 8'hFF, 1'b0}  // R11 undefined code
  };

  function automatic logic [15:0] model(input int op, input int a, input int b,
                                        input logic [7:0] fin);
    int r, cyi;
    logic s, z, ac, p, cy;
    logic [7:0] rb, acc_out;
    cyi = fin[0];
    cy  = fin[0];
    ac  = 1'b0;
    r   = a;
    acc_out = a[7:0];
    case (op)
      0: begin r = a + b; cy = (r > 255); ac = ((a % 16) + (b % 16)) > 15; end
      1: begin r = a + b + cyi; cy = (r > 255); ac = ((a % 16) + (b % 16) + cyi) > 15; end
      2, 7: begin r = a - b; cy = (a < b); ac = (a % 16) < (b % 16); end
      3: begin r = a - b - cyi; cy = (a < b + cyi); ac = (a % 16) < ((b % 16) + cyi); end
      4: begin r = a & b; cy = 1'b0; ac = 1'b1; end
      5: begin r = a | b; cy = 1'b0; ac = 1'b0; end
      6: begin r = a ^ b; cy = 1'b0; ac = 1'b0; end
      8: begin r = a + 1; ac = (a % 16) == 15; end
      9: begin r = a - 1; ac = (a % 16) == 0; end
      default: return {a[7:0], fin};
    endcase
    rb = r[7:0];
    s  = rb[7];
    z  = (rb == 8'h00);
    p  = ~(^rb);
    if (op != 7) acc_out = rb;
    return {acc_out, s, z, 1'b0, ac, 1'b0, p, 1'b1, cy};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs from a falling edge; results visible at the next falling edge.
  task automatic step(input logic ld, input logic [7:0] ldat, input logic v,
                      input logic [3:0] op, input logic [7:0] b);
    @(negedge clk);
    acc_load  = ld;
    load_data = ldat;
    op_valid  = v;
    op_sel    = op;
    operand   = b;
    @(negedge clk);
    acc_load  = 1'b0;
    op_valid  = 1'b0;
  endtask

  task automatic set_cy(input logic c);
    if (c) begin
      step(1'b1, 8'hFF, 1'b0, 4'd0, 8'h00);
      step(1'b0, 8'h00, 1'b1, 4'd0, 8'h01);
    end else begin
      step(1'b1, 8'h00, 1'b0, 4'd0, 8'h00);
      step(1'b0, 8'h00, 1'b1, 4'd0, 8'h00);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    logic [7:0]  fin;
    logic [15:0] exp;
    rst_n = 1'b0; acc_load = 1'b0; load_data = '0; op_valid = 1'b0; op_sel = '0; operand = '0;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    check("R1", "acc/flags in reset", {acc_q, flags_q}, 16'h0002);
    check("R10", "psw in reset", psw_q, 16'h0002);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "state after release", psw_q, 16'h0002);

    // R11: op_valid low with a valid code has no effect
    step(1'b0, 8'h00, 1'b0, 4'd0, 8'h55);
    check("R11", "idle op", psw_q, 16'h0002);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] op;
      logic [7:0] a, b;
      logic       c;
      {op, a, b, c} = VEC[i];
      set_cy(c);
      step(1'b1, a, 1'b0, 4'd0, 8'h00);
      fin = flags_q;
      exp = model(int'(op), int'(a), int'(b), fin);
      step(1'b0, 8'h00, 1'b1, op, b);
      check("R3-R11 vec", $sformatf("vec %0d acc", i), {8'h00, acc_q}, {8'h00, exp[15:8]});
      check("R8 R10", $sformatf("vec %0d flags", i), {8'h00, flags_q}, {8'h00, exp[7:0]});
      check("R10", $sformatf("vec %0d psw", i), psw_q, {acc_q, flags_q});
    end

    // R2: load and op in the same cycle; load wins, flags kept
    set_cy(1'b1);
    fin = flags_q;
    step(1'b1, 8'h00, 1'b1, 4'd0, 8'h7F);
    check("R2", "load priority acc", {8'h00, acc_q}, 16'h0000);
    check("R2", "load keeps flags", {8'h00, flags_q}, {8'h00, fin});

    // R5: compare of 0x00 against 0x01 keeps acc, sets borrow and sign
    step(1'b1, 8'h00, 1'b0, 4'd0, 8'h00);
    step(1'b0, 8'h00, 1'b1, 4'd7, 8'h01);
    check("R5", "cmp borrow psw", psw_q, 16'h0097);

    // R9 / R3: 0x08+0x08 -> 0x10, AC set, parity odd
    step(1'b1, 8'h08, 1'b0, 4'd0, 8'h00);
    step(1'b0, 8'h00, 1'b1, 4'd0, 8'h08);
    check("R9", "nibble carry", psw_q, 16'h1012);

    // R11: undefined code with op_valid after a result
    step(1'b0, 8'h00, 1'b1, 4'd12, 8'hFF);
    check("R11", "undefined code hold", psw_q, 16'h1012);

    // R1: reset in mid-run returns to reset state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "async reset", psw_q, 16'h0002);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "after second release", psw_q, 16'h0002);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule